// File: doc/BRIEF.md
# Transmit Clock Activity Monitor

This block watches one channel's transmit clock from the free-running master clock. When the transmit clock stops, the block decides what the line side of the channel should do. A clock stuck high makes the channel send continuous marks (all ones). A clock stuck low powers the channel down and puts its line outputs in high impedance. When the clock toggles again, the channel returns to normal operation.

The same supervisor also watches the negative-rail data input. A long run of highs on that input, counted in transmit clock cycles, switches the channel to single-rail operation. A single low on that input switches it back to dual-rail operation.

The high-impedance request for the line driver combines three sources: the power-down decision, a global output-enable pin and a per-channel high-impedance control bit. One instance serves one channel, so a multi-channel device uses one instance per channel.

Top module: `txclk_supervisor`

## Requirements
- R1: `all_ones_o` rises after the transmit clock has been sampled high at HI_LIMIT+SYNC_STAGES consecutive master-clock rising edges (18 with defaults). It stays low after one fewer.
- R2: `pwr_down_o` and `line_hiz_o` rise after the transmit clock has been sampled low at LO_LIMIT+SYNC_STAGES consecutive master-clock rising edges (66 with defaults). They stay low after one fewer.
- R3: After the transmit clock changes level, any all-ones or power-down indication clears on the SYNC_STAGES+1-th master-clock edge (the 3rd with defaults). It is still present on the edge before. The two indications are never high together.
- R4: While the clock stays stuck, the indication holds for as long as the stuck level lasts. The counters saturate and never wrap.
- R5: The negative-rail input is sampled once per falling edge of the synchronised transmit clock. `single_rail_o` rises once more than RAIL_LIMIT consecutive samples (17 with defaults) are high. It stays low after exactly RAIL_LIMIT.
- R6: The first low sample of the negative-rail input clears `single_rail_o`.
- R7: `oe_i` low drives `line_hiz_o` high in the same cycle, independent of the clock state.
- R8: `hiz_req_i` high drives `line_hiz_o` high in the same cycle.
- R9: During reset, `all_ones_o`, `pwr_down_o` and `single_rail_o` are 0. `line_hiz_o` equals `!oe_i | hiz_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_i | input | 1 | Channel transmit clock, asynchronous to mclk |
| tneg_i | input | 1 | Negative-rail transmit data input |
| oe_i | input | 1 | Global output enable, low forces high impedance |
| hiz_req_i | input | 1 | Per-channel high-impedance control bit |
| all_ones_o | output | 1 | Force continuous marks on the line |
| pwr_down_o | output | 1 | Power down the channel transmitter |
| line_hiz_o | output | 1 | Line outputs to high impedance |
| single_rail_o | output | 1 | Single-rail input mode selected |

## Verification
The bench builds the block with the default parameters: thresholds of 16 and 64 master periods, a rail limit of 16 and a two-stage synchroniser. With these values, each threshold edge can be hit exactly, one edge short and one edge over. A hold of several hundred cycles drives the 5-bit high-side counter well past its natural wrap point at 32, which exposes any counter that is not saturating. A random phase drives clock runs from 1 to 80 periods together with random enable bits. Each cycle is compared against a model that works from the history of sampled transmit clock levels.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;

   typedef enum logic [1:0] {
      TX_RUN  = 2'd0,
      TX_ONES = 2'd1,
      TX_DOWN = 2'd2
   } tx_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/tcs_sync.sv
`timescale 1ns/1ps
module tcs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcs_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else begin
         sh_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) begin
            sh_q[i] <= sh_q[i-1];
         end
      end
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tcs_run_timer.sv
`timescale 1ns/1ps
module tcs_run_timer import tcs_pkg::*; #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_ok,
   output logic expired
);
   localparam int unsigned CW = cnt_bits(LIMIT);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!level_ok) begin
         run_q <= '0;
      end else if (run_q != LIM_V) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign expired = (run_q == LIM_V);
endmodule

// File: rtl/tcs_rail_detect.sv
`timescale 1ns/1ps
module tcs_rail_detect import tcs_pkg::*; #(
   parameter int unsigned RUN_LIMIT      = 16,
   parameter bit          SAMPLE_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_lvl,
   input  logic neg_lvl,
   output logic single_rail
);
   localparam int unsigned TARGET = RUN_LIMIT + 1;
   localparam int unsigned CW     = cnt_bits(TARGET);
   localparam logic [CW-1:0] TGT_V = CW'(TARGET);

   logic          prev_q;
   logic          strobe;
   logic [CW-1:0] ones_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= clk_lvl;
   end

   generate
      if (SAMPLE_ON_FALL) begin : g_fall
         assign strobe = prev_q & ~clk_lvl;
      end else begin : g_rise
         assign strobe = ~prev_q & clk_lvl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (strobe) begin
         if (!neg_lvl)             ones_q <= '0;
         else if (ones_q != TGT_V) ones_q <= ones_q + 1'b1;
      end
   end

   assign single_rail = (ones_q == TGT_V);
endmodule

// File: rtl/txclk_supervisor.sv
`timescale 1ns/1ps
module txclk_supervisor import tcs_pkg::*; #(
   parameter int unsigned HI_LIMIT       = 16,
   parameter int unsigned LO_LIMIT       = 64,
   parameter int unsigned RAIL_LIMIT     = 16,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          SAMPLE_ON_FALL = 1'b1
) (
   input  logic mclk,
   input  logic rst_n,
   input  logic tclk_i,
   input  logic tneg_i,
   input  logic oe_i,
   input  logic hiz_req_i,
   output logic all_ones_o,
   output logic pwr_down_o,
   output logic line_hiz_o,
   output logic single_rail_o
);
   generate
      if (HI_LIMIT < 2)    begin : g_bad_hi   $error("HI_LIMIT must be at least 2");   end
      if (LO_LIMIT < 2)    begin : g_bad_lo   $error("LO_LIMIT must be at least 2");   end
      if (RAIL_LIMIT < 1)  begin : g_bad_rail $error("RAIL_LIMIT must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic     tclk_lvl;
   logic     tneg_lvl;
   logic     hi_stuck;
   logic     lo_stuck;
   tx_mode_e mode;

   tcs_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(mclk), .rst_n(rst_n), .d(tclk_i), .q(tclk_lvl)
   );

   tcs_sync #(.STAGES(SYNC_STAGES)) u_sync_neg (
      .clk(mclk), .rst_n(rst_n), .d(tneg_i), .q(tneg_lvl)
   );

   tcs_run_timer #(.LIMIT(HI_LIMIT)) u_hi_timer (
      .clk(mclk), .rst_n(rst_n), .level_ok(tclk_lvl), .expired(hi_stuck)
   );

   tcs_run_timer #(.LIMIT(LO_LIMIT)) u_lo_timer (
      .clk(mclk), .rst_n(rst_n), .level_ok(~tclk_lvl), .expired(lo_stuck)
   );

   tcs_rail_detect #(.RUN_LIMIT(RAIL_LIMIT), .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_rail (
      .clk(mclk), .rst_n(rst_n), .clk_lvl(tclk_lvl), .neg_lvl(tneg_lvl),
      .single_rail(single_rail_o)
   );

   always_comb begin
      if (lo_stuck)      mode = TX_DOWN;
      else if (hi_stuck) mode = TX_ONES;
      else               mode = TX_RUN;
   end

   assign all_ones_o = (mode == TX_ONES);
   assign pwr_down_o = (mode == TX_DOWN);
   assign line_hiz_o = pwr_down_o | ~oe_i | hiz_req_i;
endmodule

// File: rtl/tcs_checker.sv
`timescale 1ns/1ps
module tcs_checker (
   input logic mclk,
   input logic rst_n,
   input logic tclk_i,
   input logic tneg_i,
   input logic oe_i,
   input logic hiz_req_i,
   input logic all_ones_o,
   input logic pwr_down_o,
   input logic line_hiz_o,
   input logic single_rail_o
);
   p_ones_needs_high_r1: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(all_ones_o) |-> $past(tclk_i, 3));

   p_down_drives_hiz_r2: assert property (@(posedge mclk) disable iff (!rst_n)
      pwr_down_o |-> line_hiz_o);

   p_exclusive_r3: assert property (@(posedge mclk) disable iff (!rst_n)
      !(all_ones_o && pwr_down_o));

   p_ones_hold_r4: assert property (@(posedge mclk) disable iff (!rst_n)
      (all_ones_o && $past(tclk_i, 2)) |=> all_ones_o);

   p_down_hold_r4: assert property (@(posedge mclk) disable iff (!rst_n)
      (pwr_down_o && !$past(tclk_i, 2)) |=> pwr_down_o);

   p_rail_needs_neg_r5: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(single_rail_o) |-> $past(tneg_i, 3));

   p_oe_forces_hiz_r7: assert property (@(posedge mclk) disable iff (!rst_n)
      !oe_i |-> line_hiz_o);

   p_bit_forces_hiz_r8: assert property (@(posedge mclk) disable iff (!rst_n)
      hiz_req_i |-> line_hiz_o);
endmodule

bind txclk_supervisor tcs_checker u_tcs_checker (
   .mclk(mclk), .rst_n(rst_n), .tclk_i(tclk_i), .tneg_i(tneg_i),
   .oe_i(oe_i), .hiz_req_i(hiz_req_i), .all_ones_o(all_ones_o),
   .pwr_down_o(pwr_down_o), .line_hiz_o(line_hiz_o),
   .single_rail_o(single_rail_o)
);

// File: tb/txclk_supervisor_bench.sv
`timescale 1ns/1ps
module txclk_supervisor_bench;
   logic mclk = 1'b0;
   logic rst_n = 1'b0;
   logic tclk = 1'b0;
   logic tneg = 1'b0;
   logic oe = 1'b1;
   logic hiz = 1'b0;
   logic all_ones, pwr_down, line_hiz, single_rail;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [79:0] hist = '0;

   always #10 mclk = ~mclk;

   txclk_supervisor u_txclk_supervisor (
      .mclk(mclk), .rst_n(rst_n), .tclk_i(tclk), .tneg_i(tneg),
      .oe_i(oe), .hiz_req_i(hiz), .all_ones_o(all_ones),
      .pwr_down_o(pwr_down), .line_hiz_o(line_hiz),
      .single_rail_o(single_rail)
   );

   // Expected values from the sampled history: entry 0 is the level at the latest edge.
   function automatic bit exp_ones(input logic [79:0] h);
      return &h[17:2];
   endfunction
   function automatic bit exp_down(input logic [79:0] h);
      return ~|h[65:2];
   endfunction

   task automatic check(input bit act, input bit exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge mclk);
         hist = {hist[78:0], tclk};
      end
   endtask

   task automatic toggle(input int n);
      for (int i = 0; i < n; i++) begin
         tclk = 1'b1; ticks(4);
         tclk = 1'b0; ticks(4);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      bit ok;
      int run_left;
      void'($urandom(32'd4711));

      // R9: state held in reset
      ticks(5);
      check(all_ones, 1'b0, "R9 all_ones in reset");
      check(pwr_down, 1'b0, "R9 pwr_down in reset");
      check(single_rail, 1'b0, "R9 single_rail in reset");
      check(line_hiz, 1'b0, "R9 line_hiz in reset");
      rst_n = 1'b1;
      toggle(4);

      // R1: stuck high threshold
      tclk = 1'b1;
      ticks(17);
      check(all_ones, 1'b0, "R1 one edge short");
      ticks(1);
      check(all_ones, 1'b1, "R1 at threshold");
      check(pwr_down, 1'b0, "R3 no power-down while high");

      // R4: saturation while stuck high
      ok = 1'b1;
      for (int i = 0; i < 300; i++) begin
         ticks(1);
         if (all_ones !== 1'b1) ok = 1'b0;
      end
      check(ok, 1'b1, "R4 all_ones held for 300 cycles");

      // R3: release from all ones
      tclk = 1'b0;
      ticks(2);
      check(all_ones, 1'b1, "R3 all_ones before release edge");
      ticks(1);
      check(all_ones, 1'b0, "R3 all_ones released");

      // R2: stuck low threshold (3 low edges already seen)
      ticks(62);
      check(pwr_down, 1'b0, "R2 one edge short");
      ticks(1);
      check(pwr_down, 1'b1, "R2 at threshold");
      check(line_hiz, 1'b1, "R2 line_hiz with power-down");

      ok = 1'b1;
      for (int i = 0; i < 200; i++) begin
         ticks(1);
         if (pwr_down !== 1'b1) ok = 1'b0;
      end
      check(ok, 1'b1, "R4 pwr_down held for 200 cycles");

      tclk = 1'b1;
      ticks(2);
      check(pwr_down, 1'b1, "R3 pwr_down before release edge");
      ticks(1);
      check(pwr_down, 1'b0, "R3 pwr_down released");
      check(line_hiz, 1'b0, "R3 line_hiz released");
      tclk = 1'b0;
      ticks(4);

      // R5 / R6: rail auto-detection
      tneg = 1'b1;
      toggle(16);
      check(single_rail, 1'b0, "R5 after exactly 16 high samples");
      toggle(1);
      check(single_rail, 1'b1, "R5 after 17 high samples");
      tneg = 1'b0;
      tclk = 1'b1; ticks(4);
      check(single_rail, 1'b1, "R6 held until next sample");
      tclk = 1'b0; ticks(4);
      check(single_rail, 1'b0, "R6 cleared on first low sample");

      // R7 / R8: high-impedance controls
      oe = 1'b0; #1;
      check(line_hiz, 1'b1, "R7 oe low");
      oe = 1'b1; hiz = 1'b1; #1;
      check(line_hiz, 1'b1, "R8 register bit");
      hiz = 1'b0; #1;
      check(line_hiz, 1'b0, "R7 R8 both released");

      // Random phase: R1 R2 R3 R7 R8 against history model
      run_left = 1;
      for (int i = 0; i < 4000; i++) begin
         ticks(1);
         check(all_ones, exp_ones(hist), "R1 random all_ones");
         check(pwr_down, exp_down(hist), "R2 random pwr_down");
         check(line_hiz, exp_down(hist) | ~oe | hiz, "R8 random line_hiz");
         check(single_rail, 1'b0, "R6 random single_rail");
         run_left--;
         if (run_left == 0) begin
            tclk = ~tclk;
            run_left = ($urandom_range(0, 3) == 0) ? int'($urandom_range(10, 80))
                                                   : int'($urandom_range(1, 6));
         end
         oe  = ($urandom_range(0, 7) != 0);
         hiz = ($urandom_range(0, 7) == 0);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule